// File: doc/BRIEF.md
# Ciphertext Sync Hunter with Seed Capture

This block sits beside a self-synchronising cipher-feedback datapath and watches the serial ciphertext stream one qualified bit at a time. It slides a short comparison window over the stream. When the newest window contents equal the programmed sync word, it switches from hunting to capturing. The following block-length run of ciphertext bits is then assembled into a fresh seed word for the block cipher's input register. The hunt is switched off for the whole capture. When the seed is complete, a one-cycle strobe announces it and the hunt resumes from an emptied window.

Transmitter and receiver both observe the same ciphertext, so one copy of the block serves either side. At the moment of detection it also reports how many seed bits will land past the next cipher block boundary. The neighbouring queue logic uses this count to reseed the cipher part-way through a block. A free-running position counter, advanced by every qualified bit since reset, defines the block boundaries.

Top module: `ivsync_top`

## Requirements
- R1: After reset, iv_o is all zeros, iv_new_o and loading_o are low, overhang_o is zero, and the comparison window is empty (all zeros).
- R2: While hunting, if the last SYNC_W qualified bits equal sync_pat_i, loading_o is high from the clock edge that samples the final bit of the match. The earliest of those bits is compared with the most significant pattern bit.
- R3: Once loading, the next BLK_W qualified bits form iv_o. The first bit received lands in bit BLK_W-1 and the last in bit 0.
- R4: iv_new_o is high for exactly one cycle, from the edge that samples the last seed bit. loading_o falls on that same edge.
- R5: iv_o keeps its value until the next capture completes.
- R6: While loading_o is high, the pattern is not searched for. A sync word inside the seed bits neither restarts the capture nor changes overhang_o.
- R7: The window is emptied when a capture completes. A new match must therefore be made entirely of bits received after the seed.
- R8: On a match, overhang_o takes the value p+1 and holds it until the next match. Here p is the block position (0 to BLK_W-1) of the pattern's final bit, and positions count all qualified bits since reset modulo BLK_W. The range of overhang_o is 1 to BLK_W.
- R9: A bit presented with ct_vld_i low is ignored. It is not shifted into the window, not taken as a seed bit and does not advance the block position.
- R10: The pattern compared is the value on sync_pat_i at the edge where the final bit of the match is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ct_bit_i | input | 1 | Ciphertext bit |
| ct_vld_i | input | 1 | Qualifies ct_bit_i for this cycle |
| sync_pat_i | input | SYNC_W (8) | Sync word to hunt for |
| iv_o | output | BLK_W (128) | Last completed seed word |
| iv_new_o | output | 1 | One-cycle strobe: iv_o just updated |
| loading_o | output | 1 | Seed capture in progress, hunt suspended |
| overhang_o | output | $clog2(BLK_W+1) (8) | Seed bits lying past the current block boundary |

## Verification
Two things can happen on the same edge: the position counter wraps at a block boundary, and either a match or a capture completion occurs. The bench places the sync word so that its last bit sits at the final position of a block. It then expects an overhang of BLK_W, and the capture that follows ends exactly on the next wrap. A later match is judged by its overhang value, which exposes any slip of the position counter. A seed whose tail, together with one following bit, would form the sync word checks that completion and window clearing coincide correctly.

// File: rtl/ivsync_pkg.sv
package ivsync_pkg;

    typedef enum logic {
        MODE_HUNT   = 1'b0,
        MODE_GATHER = 1'b1
    } mode_e;

endpackage

// File: rtl/ivsync_window.sv
module ivsync_window #(
    parameter int SYNC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              clear_i,
    input  logic              bit_i,
    input  logic [SYNC_W-1:0] pattern_i,
    output logic              hit_o
);

    logic [SYNC_W-1:0] win_d, win_q;
    logic [SYNC_W-1:0] cand;

    always_comb begin
        cand  = {win_q[SYNC_W-2:0], bit_i};
        win_d = win_q;
        if (clear_i) begin
            win_d = '0;
        end else if (shift_en) begin
            win_d = cand;
        end
        hit_o = shift_en && !clear_i && (cand == pattern_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end

    AST_WIN_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !clear_i) |=> $stable(win_q)) else $error("window moved"); // R9

endmodule

// File: rtl/ivsync_blkpos.sv
module ivsync_blkpos #(
    parameter int BLK_W = 128,
    localparam int POS_W = $clog2(BLK_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    output logic [POS_W-1:0] pos_o
);

    logic [POS_W-1:0] pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (step_i) begin
            if (pos_q == POS_W'(BLK_W - 1)) begin
                pos_d = '0;
            end else begin
                pos_d = pos_q + POS_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_d;
        end
    end

    assign pos_o = pos_q;

    AST_POS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(pos_q)) else $error("position moved"); // R9
    AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q <= POS_W'(BLK_W - 1)) else $error("position out of block"); // R8

endmodule

// File: rtl/ivsync_gather.sv
module ivsync_gather #(
    parameter int BLK_W = 128,
    localparam int CNT_W = $clog2(BLK_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             bit_i,
    output logic             done_o,
    output logic [BLK_W-1:0] iv_o,
    output logic             iv_new_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [BLK_W-1:0] sh;
        logic [BLK_W-1:0] iv;
        logic             fresh;
    } gat_t;

    gat_t g_d, g_q;
    logic last;

    always_comb begin
        g_d   = g_q;
        last  = step_i && (g_q.cnt == CNT_W'(BLK_W - 1));
        if (step_i) begin
            g_d.sh  = {g_q.sh[BLK_W-2:0], bit_i};
            g_d.cnt = last ? '0 : g_q.cnt + CNT_W'(1);
        end
        if (last) begin
            g_d.iv = g_d.sh;
        end
        g_d.fresh = last;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign done_o   = last;
    assign iv_o     = g_q.iv;
    assign iv_new_o = g_q.fresh;

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        iv_new_o |=> !iv_new_o) else $error("strobe too long"); // R4
    AST_IV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !iv_new_o |-> $stable(iv_o)) else $error("seed changed without strobe"); // R5

endmodule

// File: rtl/ivsync_top.sv
module ivsync_top #(
    parameter int SYNC_W = 8,
    parameter int BLK_W  = 128,
    localparam int POS_W = $clog2(BLK_W),
    localparam int OVH_W = $clog2(BLK_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ct_bit_i,
    input  logic              ct_vld_i,
    input  logic [SYNC_W-1:0] sync_pat_i,
    output logic [BLK_W-1:0]  iv_o,
    output logic              iv_new_o,
    output logic              loading_o,
    output logic [OVH_W-1:0]  overhang_o
);

    import ivsync_pkg::*;

    typedef struct packed {
        mode_e            mode;
        logic [OVH_W-1:0] ovh;
    } ctl_t;

    ctl_t             c_d, c_q;
    logic             hunt_step, gath_step;
    logic             hit, done;
    logic [POS_W-1:0] pos;

    assign hunt_step = ct_vld_i && (c_q.mode == MODE_HUNT);
    assign gath_step = ct_vld_i && (c_q.mode == MODE_GATHER);

    ivsync_window #(.SYNC_W(SYNC_W)) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (hunt_step),
        .clear_i   (done),
        .bit_i     (ct_bit_i),
        .pattern_i (sync_pat_i),
        .hit_o     (hit)
    );

    ivsync_blkpos #(.BLK_W(BLK_W)) u_blkpos (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (ct_vld_i),
        .pos_o  (pos)
    );

    ivsync_gather #(.BLK_W(BLK_W)) u_gather (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_i   (gath_step),
        .bit_i    (ct_bit_i),
        .done_o   (done),
        .iv_o     (iv_o),
        .iv_new_o (iv_new_o)
    );

    always_comb begin
        c_d = c_q;
        if (hit) begin
            c_d.mode = MODE_GATHER;
            c_d.ovh  = OVH_W'(pos) + OVH_W'(1);
        end
        if (done) begin
            c_d.mode = MODE_HUNT;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '{mode: MODE_HUNT, ovh: '0};
        end else begin
            c_q <= c_d;
        end
    end

    assign loading_o  = (c_q.mode == MODE_GATHER);
    assign overhang_o = c_q.ovh;

    AST_OVH_FROZEN_LOADING: assert property (@(posedge clk) disable iff (!rst_n)
        loading_o |=> $stable(overhang_o)) else $error("overhang moved in capture"); // R6
    AST_LOAD_END_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(loading_o) |-> iv_new_o) else $error("capture ended without strobe"); // R4
    AST_OVH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        overhang_o <= OVH_W'(BLK_W)) else $error("overhang range"); // R8
    AST_START_SETS_OVH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(loading_o) |-> (overhang_o != '0)) else $error("overhang not set"); // R8

endmodule

// File: tb/ivsync_top_bench.sv
`timescale 1ns/1ps
module ivsync_top_bench;

    localparam int SW = 8;
    localparam int BW = 128;
    localparam int OW = $clog2(BW + 1);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ct_bit, ct_vld;
    logic [SW-1:0] pat;
    logic [BW-1:0] iv_o;
    logic          iv_new;
    logic          loading;
    logic [OW-1:0] ovh;

    int checks = 0;
    int failures = 0;
    bit done_flag = 0;

    // reference state, derived from the requirements
    int            m_pos, m_cnt;
    logic [SW-1:0] m_win;
    logic          m_load, m_new;
    logic [BW-1:0] m_sh, m_iv;
    logic [OW-1:0] m_ovh;

    always #2 clk = ~clk;

    ivsync_top u_ivsync_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .ct_bit_i   (ct_bit),
        .ct_vld_i   (ct_vld),
        .sync_pat_i (pat),
        .iv_o       (iv_o),
        .iv_new_o   (iv_new),
        .loading_o  (loading),
        .overhang_o (ovh)
    );

    task automatic chk(input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [SW-1:0] shift_in(input logic [SW-1:0] w, input logic b);
        return {w[SW-2:0], b};
    endfunction

    task automatic model_step(input logic b, input logic v);
        logic [SW-1:0] w;
        m_new = 1'b0;
        if (v) begin
            if (!m_load) begin
                w = shift_in(m_win, b);
                m_win = w;
                if (w == pat) begin
                    m_load = 1'b1;
                    m_cnt  = 0;
                    m_ovh  = OW'(m_pos + 1);
                end
            end else begin
                m_sh = {m_sh[BW-2:0], b};
                if (m_cnt == BW - 1) begin
                    m_load = 1'b0;
                    m_iv   = m_sh;
                    m_new  = 1'b1;
                    m_win  = '0;
                    m_cnt  = 0;
                end else begin
                    m_cnt++;
                end
            end
            m_pos = (m_pos + 1) % BW;
        end
    endtask

    task automatic step(input logic b, input logic v);
        @(negedge clk);
        ct_bit = b;
        ct_vld = v;
        @(posedge clk);
        #1;
        model_step(b, v);
        chk("R2 loading", BW'(loading), BW'(m_load));
        chk("R3 iv", iv_o, m_iv);
        chk("R4 strobe", BW'(iv_new), BW'(m_new));
        chk("R8 overhang", BW'(ovh), BW'(m_ovh));
    endtask

    task automatic send_byte(input logic [SW-1:0] by);
        for (int i = SW - 1; i >= 0; i--) step(by[i], 1'b1);
    endtask

    initial begin
        #400000;
        if (!done_flag) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [BW-1:0] seed;
        logic [BW-1:0] kept;
        void'($urandom(32'd4242));
        rst_n = 1'b0; ct_bit = 1'b0; ct_vld = 1'b0; pat = 8'b1000_0000;
        m_pos = 0; m_cnt = 0; m_win = '0; m_load = 0; m_new = 0;
        m_sh = '0; m_iv = '0; m_ovh = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset values
        chk("R1 iv", iv_o, '0);
        chk("R1 strobe", BW'(iv_new), '0);
        chk("R1 loading", BW'(loading), '0);
        chk("R1 overhang", BW'(ovh), '0);

        // R1: empty window does not match (8 zeros after reset)
        for (int i = 0; i < 120; i++) step(1'b0, 1'b1);
        chk("R1 no false match", BW'(loading), '0);
        // pattern ends at block position 127 -> overhang BW
        send_byte(8'b1000_0000);
        chk("R2 detect", BW'(loading), 1);
        chk("R8 boundary overhang", BW'(ovh), BW'(BW));

        // seed: embedded sync word first, tail 1000000
        seed = {8'b1000_0000, 113'(({$urandom(), $urandom(), $urandom(), $urandom()})), 7'b100_0000};
        for (int i = BW - 1; i >= 0; i--) begin
            step(seed[i], 1'b1);
            if (i == BW - 8) begin
                chk("R6 still loading", BW'(loading), 1);
                chk("R6 overhang kept", BW'(ovh), BW'(BW));
            end
        end
        chk("R4 strobe at end", BW'(iv_new), 1);
        chk("R4 loading fell", BW'(loading), 0);
        chk("R3 seed order", iv_o, seed);
        step(1'b0, 1'b1);
        chk("R4 strobe single", BW'(iv_new), 0);
        chk("R7 window cleared", BW'(loading), 0);

        // R9: invalid ones must not enter the window or move the position
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
        for (int i = 0; i < 7; i++) step(1'b0, 1'b1);
        chk("R9 invalid bits ignored", BW'(loading), 0);
        send_byte(8'b1000_0000);
        chk("R9 position not advanced", BW'(ovh), 16);
        kept = BW'({$urandom(), $urandom(), $urandom(), $urandom()});
        for (int i = BW - 1; i >= 0; i--) step(kept[i], 1'b1);
        chk("R3 second seed", iv_o, kept);

        // R5: seed held while hunting without a match
        for (int i = 0; i < 40; i++) step(1'b1, 1'b1);
        chk("R5 seed held", iv_o, kept);

        // R10: runtime pattern
        pat = 8'b1100_1010;
        send_byte(8'b1100_1010);
        chk("R10 new pattern", BW'(loading), 1);
        for (int i = 0; i < BW; i++) step(1'($urandom()), 1'b1);

        // constrained random mix
        for (int n = 0; n < 30000; n++) begin
            if (n % 6000 == 0) pat = (n % 12000 == 0) ? 8'b1000_0000 : 8'b0111_1110;
            step(($urandom() % 8) == 0 ? 1'b1 : (pat[1] & ($urandom() % 2 == 0)),
                 ($urandom() % 8) != 0);
        end

        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule